// File: doc/BRIEF.md
# Grouped Interrupt Summary with End-of-Interrupt Re-arm

This block sits between a large set of per-pin interrupt detectors and a host processor. Each detector supplies one pending flag. The block ORs those flags in groups of four neighbouring pins into a 46-bit summary vector, which the host reads through a small word-addressed register port as a low word and a high word. A single interrupt line tells the host that at least one group has something pending.

The interrupt line does not simply follow the OR of all pending flags. When it fires, the line stays high until the host writes the end-of-interrupt bit in the control register. That write clears the line and re-arms the unit. If pins are still pending at that point, the line rises again one cycle later. The host therefore gets a fresh edge for work that was left over, and the line does not flicker while the handler is running.

Detection, debounce and the per-pin registers are outside this block. Register reads are combinational from the address. A write takes effect at the clock edge where the write strobe is high.

Top module: `irq_summary_eoi`

## Requirements
- R1: Summary bit n is the OR of the pending inputs of pins 4n, 4n+1, 4n+2 and 4n+3. Pin indices at or above the pin count contribute zero.
- R2: A read at word address 0 returns summary bits 31..0, with summary bit k at data bit k.
- R3: A read at word address 1 returns summary bits 45..32 on data bits 13..0. Data bits 31..14 read zero.
- R4: The control register at word address 2 always reads zero, and this includes its end-of-interrupt bit (data bit 0).
- R5: While reset is low at a clock edge, the interrupt output is low after that edge, and the unit comes out of reset armed.
- R6: If the unit is armed and any summary bit is set at a clock edge with no end-of-interrupt write, the interrupt output is high after that edge. If nothing is pending, the output stays low.
- R7: Once the interrupt output is high, it stays high until an end-of-interrupt write. It stays high when all pending inputs clear, and new events have no effect on it.
- R8: A write to address 2 with data bit 0 set is an end-of-interrupt. The output is low after that edge and the unit re-arms, so the output is high again one cycle later if anything is still pending.
- R9: A write to address 2 with data bit 0 clear, or a write to any other address, leaves the interrupt output unchanged.
- R10: A read at any word address other than 0, 1 or 2 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_pending_i | input | 184 | Pending flag of each pin, bit i for pin i |
| reg_wr_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | 4 | Word address for reads and writes |
| reg_wdata_i | input | 32 | Write data; bit 0 is the end-of-interrupt request at address 2 |
| reg_rdata_o | output | 32 | Read data for the current address (combinational) |
| host_irq_o | output | 1 | Interrupt line to the host |

## Verification
The block holds only one bit of state: whether it has fired and is waiting for end-of-interrupt. That bit drives the interrupt line directly. A wrong value therefore shows on host_irq_o in the cycle right after the edge that produced it, such as a missed re-fire after end-of-interrupt, a drop when the pending flags clear, or a reaction to a write that is not an end-of-interrupt. A wrong grouping or word split in the summary has no stored state. It shows on reg_rdata_o in the same cycle as the read, so the bench sweeps a single pending pin across every pin index and also reads several multi-pin patterns.

// File: rtl/irq_summary_pkg.sv
// Package: shared types for the grouped interrupt summary block.
// Assumes: the register port decodes to one of four selections.
package irq_summary_pkg;

    // Register selection that the address decoder produces
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_SUM_LO = 2'd1,
        SEL_SUM_HI = 2'd2,
        SEL_CTRL   = 2'd3
    } reg_sel_e;

    // Number of groups needed to cover a pin count
    function automatic int groups_for(input int pins, input int group_size);
        return (pins + group_size - 1) / group_size;
    endfunction

endpackage

// File: rtl/irq_group_reduce.sv
// Module: irq_group_reduce
// Purpose: ORs the pending flags of each run of GROUP_SIZE neighbouring
//          pins into one summary bit.
// Assumes: pins beyond NUM_PINS in the last group count as not pending.
module irq_group_reduce #(
    parameter int NUM_PINS   = 184,
    parameter int GROUP_SIZE = 4,
    parameter int NUM_GROUPS = 46
) (
    input  logic [NUM_PINS-1:0]   pin_pending_i,
    output logic [NUM_GROUPS-1:0] summary_o
);

    localparam int PAD_W = NUM_GROUPS * GROUP_SIZE;

    logic [PAD_W-1:0] pending_pad;

    // Widen the pin vector to a whole number of groups, filling with zero
    always_comb begin
        pending_pad                = '0;
        pending_pad[NUM_PINS-1:0]  = pin_pending_i;
    end

    // One OR reduction per group
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
        assign summary_o[g] = |pending_pad[g*GROUP_SIZE +: GROUP_SIZE];
    end

endmodule

// File: rtl/irq_reg_decode.sv
// Module: irq_reg_decode
// Purpose: turns the word address into a register selection and detects
//          an end-of-interrupt write.
// Assumes: the three register addresses are distinct and fit in ADDR_W.
module irq_reg_decode
    import irq_summary_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int ADDR_SUM_LO = 0,
    parameter int ADDR_SUM_HI = 1,
    parameter int ADDR_CTRL   = 2,
    parameter int EOI_BIT     = 0
) (
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output reg_sel_e          sel_o,
    output logic              eoi_o
);

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^reg_wdata_i;

    // Map the address onto a register selection
    always_comb begin
        if (reg_addr_i == ADDR_W'(ADDR_SUM_LO)) begin
            sel_o = SEL_SUM_LO;
        end else if (reg_addr_i == ADDR_W'(ADDR_SUM_HI)) begin
            sel_o = SEL_SUM_HI;
        end else if (reg_addr_i == ADDR_W'(ADDR_CTRL)) begin
            sel_o = SEL_CTRL;
        end else begin
            sel_o = SEL_NONE;
        end
    end

    // End-of-interrupt: a write to the control word with the request bit set
    assign eoi_o = reg_wr_i && (sel_o == SEL_CTRL) && reg_wdata_i[EOI_BIT];

endmodule

// File: rtl/irq_arm_ctrl.sv
// Module: irq_arm_ctrl
// Purpose: holds the fired/armed state behind the host interrupt line.
// Assumes: eoi_i is a single-cycle request; an end-of-interrupt wins
//          over a new firing at the same edge.
module irq_arm_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic any_pending_i,
    input  logic eoi_i,
    output logic irq_o
);

    logic fired_q;

    // Fire when armed and something is pending; re-arm on end-of-interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fired_q <= 1'b0;
        end else if (eoi_i) begin
            fired_q <= 1'b0;
        end else if (!fired_q && any_pending_i) begin
            fired_q <= 1'b1;
        end
    end

    assign irq_o = fired_q;

endmodule

// File: rtl/irq_read_mux.sv
// Module: irq_read_mux
// Purpose: returns the selected register word on the read port.
// Assumes: NUM_GROUPS is greater than DATA_W and no more than 2*DATA_W.
module irq_read_mux
    import irq_summary_pkg::*;
#(
    parameter int NUM_GROUPS = 46,
    parameter int DATA_W     = 32
) (
    input  reg_sel_e              sel_i,
    input  logic [NUM_GROUPS-1:0] summary_i,
    output logic [DATA_W-1:0]     rdata_o
);

    localparam int SUM_PAD_W = 2 * DATA_W;

    logic [SUM_PAD_W-1:0] summary_pad;

    // Widen the summary to two full words, filling with zero
    always_comb begin
        summary_pad                 = '0;
        summary_pad[NUM_GROUPS-1:0] = summary_i;
    end

    // Choose the read word; the control word and unmapped space read zero
    always_comb begin
        unique case (sel_i)
            SEL_SUM_LO: rdata_o = summary_pad[DATA_W-1:0];
            SEL_SUM_HI: rdata_o = summary_pad[SUM_PAD_W-1:DATA_W];
            default:    rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_summary_eoi.sv
// Module: irq_summary_eoi (top)
// Purpose: groups per-pin pending flags into a two-word summary and drives
//          one host interrupt that re-arms only on end-of-interrupt.
// Assumes: reset is synchronous and active low; reads are combinational.
module irq_summary_eoi
    import irq_summary_pkg::*;
#(
    parameter int NUM_PINS    = 184,
    parameter int GROUP_SIZE  = 4,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 4,
    parameter int ADDR_SUM_LO = 0,
    parameter int ADDR_SUM_HI = 1,
    parameter int ADDR_CTRL   = 2,
    parameter int EOI_BIT     = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_pending_i,
    input  logic                reg_wr_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    output logic                host_irq_o
);

    localparam int NUM_GROUPS = groups_for(NUM_PINS, GROUP_SIZE);

    logic [NUM_GROUPS-1:0] summary;
    reg_sel_e              sel;
    logic                  eoi;

    irq_group_reduce #(
        .NUM_PINS   (NUM_PINS),
        .GROUP_SIZE (GROUP_SIZE),
        .NUM_GROUPS (NUM_GROUPS)
    ) u_reduce (
        .pin_pending_i (pin_pending_i),
        .summary_o     (summary)
    );

    irq_reg_decode #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .ADDR_SUM_LO (ADDR_SUM_LO),
        .ADDR_SUM_HI (ADDR_SUM_HI),
        .ADDR_CTRL   (ADDR_CTRL),
        .EOI_BIT     (EOI_BIT)
    ) u_decode (
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .sel_o       (sel),
        .eoi_o       (eoi)
    );

    irq_arm_ctrl u_arm (
        .clk           (clk),
        .rst_n         (rst_n),
        .any_pending_i (|summary),
        .eoi_i         (eoi),
        .irq_o         (host_irq_o)
    );

    irq_read_mux #(
        .NUM_GROUPS (NUM_GROUPS),
        .DATA_W     (DATA_W)
    ) u_rmux (
        .sel_i     (sel),
        .summary_i (summary),
        .rdata_o   (reg_rdata_o)
    );

endmodule

// File: rtl/irq_summary_eoi_chk.sv
// Module: irq_summary_eoi_chk
// Purpose: port-level properties of the interrupt summary block, bound
//          into every instance of the top module.
// Assumes: the same parameter values as the bound instance.
module irq_summary_eoi_chk #(
    parameter int NUM_PINS    = 184,
    parameter int GROUP_SIZE  = 4,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 4,
    parameter int ADDR_SUM_LO = 0,
    parameter int ADDR_SUM_HI = 1,
    parameter int ADDR_CTRL   = 2,
    parameter int EOI_BIT     = 0
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] pin_pending_i,
    input logic                reg_wr_i,
    input logic [ADDR_W-1:0]   reg_addr_i,
    input logic [DATA_W-1:0]   reg_wdata_i,
    input logic [DATA_W-1:0]   reg_rdata_o,
    input logic                host_irq_o
);

    localparam int NUM_GROUPS = (NUM_PINS + GROUP_SIZE - 1) / GROUP_SIZE;
    localparam int HI_VALID   = NUM_GROUPS - DATA_W;

    logic eoi_seen;
    logic any_pin;
    logic unused_chk_wdata;

    assign eoi_seen = reg_wr_i && (reg_addr_i == ADDR_W'(ADDR_CTRL))
                      && reg_wdata_i[EOI_BIT];
    assign any_pin  = |pin_pending_i;
    assign unused_chk_wdata = ^reg_wdata_i;

    // R5: reset leaves the line low
    a_r5_reset_low: assert property (@(posedge clk)
        !rst_n |=> !host_irq_o);

    // R6: armed with something pending fires on the next edge
    a_r6_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_irq_o && any_pin && !eoi_seen) |=> host_irq_o);

    // R6: nothing pending and not fired keeps the line low
    a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_irq_o && !any_pin) |=> !host_irq_o);

    // R7: a fired line holds until end-of-interrupt
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq_o && !eoi_seen) |=> host_irq_o);

    // R8: end-of-interrupt drops the line
    a_r8_eoi_drop: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_seen |=> !host_irq_o);

    // R2: group 0 appears at bit 0 of the low word
    a_r2_low_group0: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == ADDR_W'(ADDR_SUM_LO))
        |-> (reg_rdata_o[0] == |pin_pending_i[GROUP_SIZE-1:0]));

    // R3: bits above the last valid group read zero in the high word
    a_r3_high_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == ADDR_W'(ADDR_SUM_HI)) |-> ((reg_rdata_o >> HI_VALID) == '0));

    // R4: the control word reads zero
    a_r4_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == ADDR_W'(ADDR_CTRL)) |-> (reg_rdata_o == '0));

endmodule

bind irq_summary_eoi irq_summary_eoi_chk #(
    .NUM_PINS    (NUM_PINS),
    .GROUP_SIZE  (GROUP_SIZE),
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .ADDR_SUM_LO (ADDR_SUM_LO),
    .ADDR_SUM_HI (ADDR_SUM_HI),
    .ADDR_CTRL   (ADDR_CTRL),
    .EOI_BIT     (EOI_BIT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pin_pending_i (pin_pending_i),
    .reg_wr_i      (reg_wr_i),
    .reg_addr_i    (reg_addr_i),
    .reg_wdata_i   (reg_wdata_i),
    .reg_rdata_o   (reg_rdata_o),
    .host_irq_o    (host_irq_o)
);

// File: tb/irq_summary_eoi_tb.sv
// Bench: a behavioural model of the interrupt line and of the summary words,
// compared with the outputs on every cycle.
module irq_summary_eoi_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 184;
    localparam int WATCHDOG   = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic          wr = 1'b0;
    logic [3:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    int waiting = 0;   // model: 1 while the line is up and awaiting end-of-interrupt

    irq_summary_eoi u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_pending_i (pins),
        .reg_wr_i      (wr),
        .reg_addr_i    (addr),
        .reg_wdata_i   (wdata),
        .reg_rdata_o   (rdata),
        .host_irq_o    (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural summary: 64 bits, bit g set when any pin 4g..4g+3 pends
    function automatic logic [63:0] model_summary(input logic [NP-1:0] p);
        logic [63:0] s = '0;
        for (int i = 0; i < NP; i++) begin
            if (p[i]) s[i/4] = 1'b1;
        end
        return s;
    endfunction

    function automatic logic [31:0] model_read(input logic [3:0] a, input logic [NP-1:0] p);
        logic [63:0] s = model_summary(p);
        if (a == 4'd0) return s[31:0];
        if (a == 4'd1) return {18'd0, s[45:32]};
        return 32'd0;
    endfunction

    // Model of the line, advanced at each rising edge
    always @(posedge clk) begin
        if (!rst_n) waiting <= 0;
        else if (wr && addr == 4'd2 && wdata[0]) waiting <= 0;
        else if (pins != '0) waiting <= 1;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply inputs after a falling edge, then compare both outputs with the model
    task automatic step(input logic [NP-1:0] p, input logic w, input logic [3:0] a,
                        input logic [31:0] d, input string tag);
        @(negedge clk);
        pins = p; wr = w; addr = a; wdata = d;
        #1;
        check({tag, " irq"}, {31'd0, irq}, waiting[31:0]);
        check({tag, " rdata"}, rdata, model_read(a, p));
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [NP-1:0] one;
        // R5: reset with pins pending keeps the line low
        step({NP{1'b1}}, 1'b0, 4'd0, '0, "R5 in reset");
        step({NP{1'b1}}, 1'b0, 4'd2, '0, "R5 in reset");
        @(negedge clk); rst_n = 1'b1; pins = '0;
        #1; check("R5 after reset", {31'd0, irq}, 32'd0);

        // R6: nothing pending stays quiet
        step('0, 1'b0, 4'd0, '0, "R6 idle");
        step('0, 1'b0, 4'd1, '0, "R6 idle");

        // R1 R2 R3: one pin at a time across every index, read its word
        for (int i = 0; i < NP; i++) begin
            one = '0; one[i] = 1'b1;
            step(one, 1'b0, (i/4 < 32) ? 4'd0 : 4'd1, '0, "R1 R2 R3 sweep");
        end
        // R7: line holds after pending clears and under new events
        check("R7 held", {31'd0, irq}, 32'd1);
        step('0, 1'b0, 4'd0, '0, "R7 cleared pins");
        step('0, 1'b0, 4'd0, '0, "R7 cleared pins");
        check("R7 still up", {31'd0, irq}, 32'd1);

        // R9: writes that are not end-of-interrupt change nothing
        step('0, 1'b1, 4'd2, 32'hFFFF_FFFE, "R9 ctrl bit0 clear");
        step('0, 1'b1, 4'd0, 32'h1, "R9 other addr");
        step('0, 1'b1, 4'd7, 32'h1, "R9 unmapped addr");
        step('0, 1'b0, 4'd0, '0, "R9 after writes");
        check("R9 line unchanged", {31'd0, irq}, 32'd1);

        // R8: end-of-interrupt with nothing pending leaves line low
        step('0, 1'b1, 4'd2, 32'h1, "R8 eoi");
        step('0, 1'b0, 4'd2, '0, "R8 after eoi");
        check("R8 dropped", {31'd0, irq}, 32'd0);
        step('0, 1'b0, 4'd2, '0, "R8 quiet");
        check("R8 stays low", {31'd0, irq}, 32'd0);

        // R6: a new event after re-arm fires again
        one = '0; one[150] = 1'b1;
        step(one, 1'b0, 4'd1, '0, "R6 new event");
        step(one, 1'b0, 4'd1, '0, "R6 fired");
        check("R6 fired", {31'd0, irq}, 32'd1);

        // R8: end-of-interrupt while still pending: low one cycle, then high
        step(one, 1'b1, 4'd2, 32'h1, "R8 eoi pending");
        step(one, 1'b0, 4'd1, '0, "R8 gap");
        check("R8 gap low", {31'd0, irq}, 32'd0);
        step(one, 1'b0, 4'd1, '0, "R8 refire");
        check("R8 refire", {31'd0, irq}, 32'd1);

        // R2 R3: multi-pin patterns
        step({NP{1'b1}}, 1'b0, 4'd0, '0, "R2 all pins low word");
        check("R2 all ones", rdata, 32'hFFFF_FFFF);
        step({NP{1'b1}}, 1'b0, 4'd1, '0, "R3 all pins high word");
        check("R3 all ones", rdata, 32'h0000_3FFF);
        step({(NP/2){2'b01}}, 1'b0, 4'd0, '0, "R2 alternating");
        step({(NP/8){8'h0F}}, 1'b0, 4'd0, '0, "R1 odd groups idle");
        check("R1 nibble pattern", rdata, 32'h5555_5555);
        step({(NP/8){8'hF0}}, 1'b0, 4'd1, '0, "R3 nibble pattern");
        check("R3 nibble pattern", rdata, 32'h0000_2AAA);

        // R4: control word reads zero even as the request is written
        step({NP{1'b1}}, 1'b1, 4'd2, 32'hFFFF_FFFF, "R4 ctrl read");
        check("R4 ctrl zero", rdata, 32'd0);
        // R10: unmapped words read zero
        for (int a = 3; a < 16; a++) begin
            step({NP{1'b1}}, 1'b0, 4'(a), '0, "R10 unmapped");
        end
        check("R10 last unmapped", rdata, 32'd0);

        // R5: reset in the middle of a fired state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); #1;
        check("R5 mid reset", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        step('0, 1'b0, 4'd0, '0, "R5 after second reset");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule